// File: doc/BRIEF.md
# Indirect SDRAM Controller Register File

This block holds the configuration and status registers of a four-bank SDRAM controller. Software reaches them through two neighbouring register numbers on a simple register bus. It first writes a sub-register offset into the index port, then reads or writes the data port, which acts on that stored offset. The block holds:

- two error-status registers and an error-address register;
- a global configuration register and a read-only status register;
- refresh, power-management, timing and ECC configuration registers;
- an ECC error-status register;
- four bank configuration registers.

From the bank registers and the global enable, the block produces a per-bank active flag and a per-bank address-hit flag for an incoming probe address. It also drives a level interrupt that follows the ECC error status.

The register bus is plain control, not a stream. A write takes effect on the rising clock edge where `reg_wr` is high. Read data is combinational and is valid in the same cycle that `reg_rd` is high. There is no back-pressure and no wait state.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write to register number 0x10 (index port) stores the 32-bit offset, which reads back from 0x10. Data-port accesses at register number 0x11 act on the stored offset.
- R2: After reset the registers read as follows: configuration 0x00800000, refresh 0x05F00000, timing 0x00854009, power-management timer 0x07C00000, all others zero, and `ecc_irq` low.
- R3: Data-port writes are masked. Refresh keeps 0x3FF80000 and timing keeps 0x018FC01F. ECC configuration keeps 0x00F00000 and bank configuration keeps 0xFFDEE001. The power-management timer keeps bits 31:27 and always reads bits 0x07C00000 set. Error address (offset 0x10), ECC error status (0x98) and configuration (0x20) store all 32 bits.
- R4: The error-status registers at offsets 0x00 and 0x08 are write-one-to-clear: each written 1 clears that bit.
- R5: Writes to the status register (offset 0x24) change nothing. Offsets without a register read zero and ignore writes.
- R6: A configuration write that takes bit 31 from 0 to 1 clears status bit 31. One that takes it from 1 to 0 sets status bit 31.
- R7: A configuration write that takes bit 30 from 0 to 1 sets status bit 30. One that takes it from 1 to 0 clears status bit 30.
- R8: `bank_active[i]` is high exactly when configuration bit 31 and bit 0 of bank register i (offset 0x40 + 4*i) are both set.
- R9: `bank_hit[i]` is high when bank i is active and base <= `probe_addr` < base + size. The base is bits 31:23 of the bank register followed by 23 zero bits. The size is 4 MiB shifted left by the code in bits 19:17, so codes 0 to 6 give 4 MiB to 256 MiB and code 7 gives 512 MiB.
- R10: A write to ECC error status (offset 0x98) sets `ecc_irq` from the next edge when the written value is non-zero, and clears it when the value is zero.
- R11: `reg_rdata` is zero unless `reg_rd` is high with register number 0x10 or 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register bus write strobe |
| reg_rd | input | 1 | Register bus read strobe |
| reg_num | input | 10 | Register number (0x10 index, 0x11 data) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| probe_addr | input | 32 | Address checked against the bank windows |
| bank_active | output | 4 | Per-bank enabled flag |
| bank_hit | output | 4 | Per-bank address hit |
| ecc_irq | output | 1 | ECC error interrupt level |

## Verification
Each register, status flag and `ecc_irq` changes on the clock edge where the write strobe is sampled. The bench therefore drives a write on a falling edge and removes it on the next falling edge, so that exactly one rising edge lies between. It samples only after that second falling edge.

Reads are combinational. The bench raises `reg_rd` after a falling edge and samples one time unit later, well before the next rising edge.

`bank_active` and `bank_hit` are combinational from the stored registers and `probe_addr`. They are sampled one time unit after `probe_addr` is set, again between edges.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int DW     = 32;
  localparam int NBANK  = 4;
  localparam int RID_W  = 4;

  localparam logic [RID_W-1:0] RID_ERR0  = 4'd0;
  localparam logic [RID_W-1:0] RID_ERR1  = 4'd1;
  localparam logic [RID_W-1:0] RID_EADDR = 4'd2;
  localparam logic [RID_W-1:0] RID_CFG   = 4'd3;
  localparam logic [RID_W-1:0] RID_STAT  = 4'd4;
  localparam logic [RID_W-1:0] RID_RFSH  = 4'd5;
  localparam logic [RID_W-1:0] RID_PMT   = 4'd6;
  localparam logic [RID_W-1:0] RID_BANK0 = 4'd7;
  localparam logic [RID_W-1:0] RID_TIM   = 4'd11;
  localparam logic [RID_W-1:0] RID_ECFG  = 4'd12;
  localparam logic [RID_W-1:0] RID_ESTAT = 4'd13;
  localparam logic [RID_W-1:0] RID_NONE  = 4'd15;

  localparam logic [DW-1:0] MASK_RFSH  = 32'h3FF8_0000;
  localparam logic [DW-1:0] MASK_TIM   = 32'h018F_C01F;
  localparam logic [DW-1:0] MASK_ECFG  = 32'h00F0_0000;
  localparam logic [DW-1:0] MASK_BANK  = 32'hFFDE_E001;
  localparam logic [DW-1:0] MASK_PMT   = 32'hF800_0000;
  localparam logic [DW-1:0] FORCE_PMT  = 32'h07C0_0000;

  localparam logic [DW-1:0] RST_CFG    = 32'h0080_0000;
  localparam logic [DW-1:0] RST_RFSH   = 32'h05F0_0000;
  localparam logic [DW-1:0] RST_TIM    = 32'h0085_4009;
  localparam logic [DW-1:0] RST_PMT    = 32'h07C0_0000;

  localparam int BANK_OFF0   = 'h40;
  localparam int BANK_STRIDE = 4;

  function automatic logic [RID_W-1:0] offset_to_rid(input logic [DW-1:0] off);
    logic [RID_W-1:0] r;
    r = RID_NONE;
    case (off)
      32'h00: r = RID_ERR0;
      32'h08: r = RID_ERR1;
      32'h10: r = RID_EADDR;
      32'h20: r = RID_CFG;
      32'h24: r = RID_STAT;
      32'h30: r = RID_RFSH;
      32'h34: r = RID_PMT;
      32'h80: r = RID_TIM;
      32'h94: r = RID_ECFG;
      32'h98: r = RID_ESTAT;
      default: r = RID_NONE;
    endcase
    for (int b = 0; b < NBANK; b++) begin
      if (off == 32'(BANK_OFF0 + BANK_STRIDE * b)) r = RID_BANK0 + RID_W'(b);
    end
    return r;
  endfunction
endpackage

// File: rtl/sdram_idx_port.sv
module sdram_idx_port
  import sdram_cfg_pkg::*;
#(
  parameter int RNUM_W = 10,
  parameter logic [RNUM_W-1:0] IDX_NUM  = 10'h010,
  parameter logic [RNUM_W-1:0] DATA_NUM = 10'h011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RNUM_W-1:0] reg_num,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     off_q,
  output logic              data_wr,
  output logic [RID_W-1:0]  rid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else if (reg_wr && reg_num == IDX_NUM) off_q <= reg_wdata;
  end

  assign data_wr = reg_wr && (reg_num == DATA_NUM);
  assign rid     = offset_to_rid(off_q);

  p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_num == IDX_NUM) |=> (off_q == $past(reg_wdata)));
  p_index_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_num == IDX_NUM) |=> $stable(off_q));
endmodule

// File: rtl/sdram_reg_store.sv
module sdram_reg_store
  import sdram_cfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      data_wr,
  input  logic [RID_W-1:0]          rid,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             sel_rdata,
  output logic [DW-1:0]             cfg_q,
  output logic [NBANK-1:0][DW-1:0]  bank_q,
  output logic                      ecc_irq
);
  logic [DW-1:0] err0_q, err1_q, eaddr_q, stat_q, rfsh_q, pmt_q, tim_q, ecfg_q, estat_q;

  wire wr_cfg = data_wr && rid == RID_CFG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err0_q  <= '0;
      err1_q  <= '0;
      eaddr_q <= '0;
      cfg_q   <= RST_CFG;
      stat_q  <= '0;
      rfsh_q  <= RST_RFSH;
      pmt_q   <= RST_PMT;
      tim_q   <= RST_TIM;
      ecfg_q  <= '0;
      estat_q <= '0;
      ecc_irq <= 1'b0;
    end else if (data_wr) begin
      case (rid)
        RID_ERR0:  err0_q  <= err0_q & ~wdata;
        RID_ERR1:  err1_q  <= err1_q & ~wdata;
        RID_EADDR: eaddr_q <= wdata;
        RID_CFG: begin
          cfg_q <= wdata;
          if (!cfg_q[31] && wdata[31])      stat_q[31] <= 1'b0;
          else if (cfg_q[31] && !wdata[31]) stat_q[31] <= 1'b1;
          if (!cfg_q[30] && wdata[30])      stat_q[30] <= 1'b1;
          else if (cfg_q[30] && !wdata[30]) stat_q[30] <= 1'b0;
        end
        RID_RFSH:  rfsh_q  <= wdata & MASK_RFSH;
        RID_PMT:   pmt_q   <= (wdata & MASK_PMT) | FORCE_PMT;
        RID_TIM:   tim_q   <= wdata & MASK_TIM;
        RID_ECFG:  ecfg_q  <= wdata & MASK_ECFG;
        RID_ESTAT: begin
          estat_q <= wdata;
          ecc_irq <= |wdata;
        end
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[b] <= '0;
      else if (data_wr && rid == RID_BANK0 + RID_W'(b)) bank_q[b] <= wdata & MASK_BANK;
    end
  end

  always_comb begin
    sel_rdata = '0;
    case (rid)
      RID_ERR0:  sel_rdata = err0_q;
      RID_ERR1:  sel_rdata = err1_q;
      RID_EADDR: sel_rdata = eaddr_q;
      RID_CFG:   sel_rdata = cfg_q;
      RID_STAT:  sel_rdata = stat_q;
      RID_RFSH:  sel_rdata = rfsh_q;
      RID_PMT:   sel_rdata = pmt_q;
      RID_TIM:   sel_rdata = tim_q;
      RID_ECFG:  sel_rdata = ecfg_q;
      RID_ESTAT: sel_rdata = estat_q;
      default:   sel_rdata = '0;
    endcase
    for (int b = 0; b < NBANK; b++) begin
      if (rid == RID_BANK0 + RID_W'(b)) sel_rdata = bank_q[b];
    end
  end

  p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && rid == RID_ERR0) |=> ((err0_q & $past(wdata)) == '0));
  p_status_ignores_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && rid == RID_STAT) |=> $stable(stat_q));
  p_enable_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !cfg_q[31] && wdata[31]) |=> !stat_q[31]);
  p_enable_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && cfg_q[31] && !wdata[31]) |=> stat_q[31]);
  p_bit30_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && cfg_q[30] != wdata[30]) |=> (stat_q[30] == $past(wdata[30])));
  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && rid == RID_ESTAT) |=> (ecc_irq == ($past(wdata) != '0)));
  p_pmt_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pmt_q & FORCE_PMT) == FORCE_PMT);
endmodule

// File: rtl/sdram_bank_decode.sv
module sdram_bank_decode
  import sdram_cfg_pkg::*;
#(
  parameter int UNIT_SHIFT = 22,
  parameter int BASE_LSB   = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_en,
  input  logic [DW-1:0] bank_cfg,
  input  logic [DW-1:0] probe_addr,
  output logic          active,
  output logic          hit
);
  localparam int EW = DW + 1;

  logic [DW-1:0] base;
  logic [2:0]    code;
  logic [EW-1:0] span;
  logic [EW-1:0] delta;

  assign base   = {bank_cfg[DW-1:BASE_LSB], {BASE_LSB{1'b0}}};
  assign code   = bank_cfg[19:17];
  assign span   = EW'(1) << (UNIT_SHIFT + int'(code));
  assign delta  = {1'b0, probe_addr} - {1'b0, base};
  assign active = ctrl_en && bank_cfg[0];
  assign hit    = active && (probe_addr >= base) && (delta < span);

  p_hit_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (ctrl_en && bank_cfg[0]));
  p_hit_above_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (probe_addr[DW-1:BASE_LSB] >= bank_cfg[DW-1:BASE_LSB]));
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int RNUM_W = 10,
  parameter logic [RNUM_W-1:0] IDX_NUM  = 10'h010,
  parameter logic [RNUM_W-1:0] DATA_NUM = 10'h011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RNUM_W-1:0] reg_num,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       probe_addr,
  output logic [3:0]        bank_active,
  output logic [3:0]        bank_hit,
  output logic              ecc_irq
);
  logic [DW-1:0]            off_q;
  logic                     data_wr;
  logic [RID_W-1:0]         rid;
  logic [DW-1:0]            sel_rdata;
  logic [DW-1:0]            cfg_q;
  logic [NBANK-1:0][DW-1:0] bank_q;

  sdram_idx_port #(.RNUM_W(RNUM_W), .IDX_NUM(IDX_NUM), .DATA_NUM(DATA_NUM)) u_idx (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_num(reg_num),
    .reg_wdata(reg_wdata), .off_q(off_q), .data_wr(data_wr), .rid(rid)
  );

  sdram_reg_store u_store (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .rid(rid), .wdata(reg_wdata),
    .sel_rdata(sel_rdata), .cfg_q(cfg_q), .bank_q(bank_q), .ecc_irq(ecc_irq)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    sdram_bank_decode u_dec (
      .clk(clk), .rst_n(rst_n), .ctrl_en(cfg_q[31]), .bank_cfg(bank_q[b]),
      .probe_addr(probe_addr), .active(bank_active[b]), .hit(bank_hit[b])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd && reg_num == IDX_NUM)       reg_rdata = off_q;
    else if (reg_rd && reg_num == DATA_NUM) reg_rdata = sel_rdata;
  end

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0));
  p_hit_is_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_hit & ~bank_active) == '0);
endmodule

// File: tb/tb_sdram_cfg_regs.sv
module tb_sdram_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [9:0]  reg_num = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] probe_addr = '0;
  logic [3:0]  bank_active;
  logic [3:0]  bank_hit;
  logic        ecc_irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [9:0] IDX = 10'h010;
  localparam logic [9:0] DAT = 10'h011;

  // {offset, write value, expected readback}
  localparam int NVEC = 10;
  localparam logic [95:0] VEC [NVEC] = '{
    {32'h30, 32'hFFFF_FFFF, 32'h3FF8_0000},
    {32'h80, 32'hFFFF_FFFF, 32'h018F_C01F},
    {32'h94, 32'hFFFF_FFFF, 32'h00F0_0000},
    {32'h34, 32'h0000_0000, 32'h07C0_0000},
    {32'h34, 32'hFFFF_FFFF, 32'hFFC0_0000},
    {32'h40, 32'hFFFF_FFFF, 32'hFFDE_E001},
    {32'h10, 32'h1234_5678, 32'h1234_5678},
    {32'h24, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h00, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h04, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  sdram_cfg_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_num(reg_num),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .probe_addr(probe_addr),
    .bank_active(bank_active), .bank_hit(bank_hit), .ecc_irq(ecc_irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] n, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_num = n; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] n, output logic [31:0] d);
    reg_rd = 1'b1; reg_num = n;
    #1;
    d = reg_rdata;
    reg_rd = 1'b0;
    #1;
  endtask

  task automatic reg_write(input logic [31:0] off, input logic [31:0] d);
    bus_wr(IDX, off);
    bus_wr(DAT, d);
  endtask

  task automatic reg_read(input logic [31:0] off, output logic [31:0] d);
    bus_wr(IDX, off);
    bus_rd(DAT, d);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset values, R11 idle read data
    chk("R11 idle rdata", reg_rdata, 32'h0);
    chk("R2 irq", {31'b0, ecc_irq}, 32'h0);
    reg_read(32'h20, v); chk("R2 cfg", v, 32'h0080_0000);
    reg_read(32'h30, v); chk("R2 refresh", v, 32'h05F0_0000);
    reg_read(32'h80, v); chk("R2 timing", v, 32'h0085_4009);
    reg_read(32'h34, v); chk("R2 pmt", v, 32'h07C0_0000);
    reg_read(32'h24, v); chk("R2 status", v, 32'h0);
    reg_read(32'h44, v); chk("R2 bank1", v, 32'h0);

    // R1 index port readback
    bus_wr(IDX, 32'h0000_0098);
    bus_rd(IDX, v); chk("R1 index readback", v, 32'h98);

    // table: R3 masks, R4 W1C, R5 status/unmapped
    for (int i = 0; i < NVEC; i++) begin
      reg_write(VEC[i][95:64], VEC[i][63:32]);
      bus_rd(DAT, v);
      chk("R3/R4/R5 vector", v, VEC[i][31:0]);
    end

    // R7 / R6 configuration transitions
    reg_write(32'h20, 32'hC000_0000);
    reg_read(32'h24, v); chk("R7 bit30 rise", v, 32'h4000_0000);
    reg_read(32'h20, v); chk("R3 cfg full write", v, 32'hC000_0000);
    reg_write(32'h20, 32'h0000_0000);
    reg_read(32'h24, v); chk("R6 bit31 fall", v, 32'h8000_0000);
    reg_write(32'h20, 32'h8000_0000);
    reg_read(32'h24, v); chk("R6 bit31 rise", v, 32'h0);

    // R8 / R9 bank decode: bank1 base 0x00800000 code 2 (16 MiB)
    reg_write(32'h44, 32'h0084_0001);
    #1;
    chk("R8 active", {28'b0, bank_active}, 32'h3);
    probe_addr = 32'h0080_0000; #1;
    chk("R9 hit base", {28'b0, bank_hit}, 32'h2);
    probe_addr = 32'h017F_FFFF; #1;
    chk("R9 hit top", {28'b0, bank_hit}, 32'h2);
    probe_addr = 32'h0180_0000; #1;
    chk("R9 miss above", {28'b0, bank_hit}, 32'h0);
    probe_addr = 32'h007F_FFFF; #1;
    chk("R9 miss below", {28'b0, bank_hit}, 32'h0);
    probe_addr = 32'hFFFF_0000; #1;
    chk("R9 bank0 code7 hit", {28'b0, bank_hit}, 32'h1);
    reg_write(32'h20, 32'h0000_0000);
    probe_addr = 32'h0080_0000; #1;
    chk("R8 disabled active", {28'b0, bank_active}, 32'h0);
    chk("R8 disabled hit", {28'b0, bank_hit}, 32'h0);

    // R10 ECC interrupt
    reg_write(32'h98, 32'h0000_0005);
    chk("R10 irq raise", {31'b0, ecc_irq}, 32'h1);
    bus_rd(DAT, v); chk("R10 estat readback", v, 32'h5);
    reg_write(32'h98, 32'h0000_0000);
    chk("R10 irq lower", {31'b0, ecc_irq}, 32'h0);

    // R5 unmapped write leaves neighbours untouched
    reg_write(32'h3C, 32'hFFFF_FFFF);
    reg_read(32'h30, v); chk("R5 neighbour kept", v, 32'h3FF8_0000);

    // R11 read of another register number
    bus_rd(10'h012, v); chk("R11 other number", v, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule